// File: doc/BRIEF.md
# Configurable Quadrature Decoder Position Counter

This block turns two encoder phase lines and an index line into a position count, a counting direction and a revolution count. Everything runs on one system clock. Each raw input first passes through a two-flop synchronizer. It then goes through a glitch filter, which accepts a new level only after the level has held for a programmable number of samples. The filtered phases feed a decoder with two signal modes. In quadrature mode the block counts in 2X or 4X. In direction/clock mode one line gives the direction and the other line gives count pulses.

The position wraps between zero and a programmable maximum. Three position-compare channels and one index-compare value drive match outputs, and each channel also has a combined match output. One-cycle command pulses clear the position, clear the index count, or arm a one-shot clear of the position on the next index pulse. One-cycle event outputs report each counted step, each direction change, each phase error and each index pulse. All configuration arrives on plain input ports.

Top module: `qdec`

## Requirements
- R1: After reset, pos_o and idx_cnt_o are 0, dir_o is 1 (up), and no event output is high.
- R2: When cfg_i[1]=0 and cfg_i[2]=1 (quadrature, 4X), every change of exactly one filtered phase moves the position by one. The order {a,b} = 00,10,11,01 (A leading) counts up, and the reverse order counts down.
- R3: When cfg_i[1]=0 and cfg_i[2]=0 (quadrature, 2X), only a lone change of phase A counts, and a lone change of B leaves the position unchanged.
- R4: Counting up from max_pos_i gives 0, and counting down from 0 gives max_pos_i.
- R5: cfg_i[0]=1 reverses the counting direction in every mode.
- R6: In quadrature mode, a filtered sample in which A and B both change raises ev_err_o for one cycle and leaves the position unchanged.
- R7: When cfg_i[1]=1 (direction/clock mode), only a rising edge of B counts. The count goes up when A=1 and down when A=0. A falling edge of B and any change of A do not count.
- R8: With filt_len_i = N, a raw change that lasts fewer than N clock cycles has no effect. A change that lasts N cycles is accepted.
- R9: Each rising edge of the active index level (the level is inverted when cfg_i[3]=1) increments idx_cnt_o and pulses ev_idx_o.
- R10: pos_hit_o[i] is high while pos_o equals compare value i, which is held in cmp_pos_i[i*POS_W +: POS_W]. rev_hit_o is high while idx_cnt_o equals idx_cmp_i. combo_hit_o[i] is high while both pos_hit_o[i] and rev_hit_o are high.
- R11: A clr_pos_i or clr_idx_i pulse zeroes its counter at the next clock edge, ahead of any step or index in the same cycle.
- R12: An arm_idx_clr_i pulse makes the next index pulse zero the position. Later index pulses leave the position unchanged until the block is armed again.
- R13: ev_step_o pulses once per counted step. ev_dir_o pulses when a counted step goes the other way from the previous counted step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| a_i | input | 1 | Raw phase A, or the direction level in direction/clock mode |
| b_i | input | 1 | Raw phase B, or the count clock in direction/clock mode |
| idx_i | input | 1 | Raw index input |
| cfg_i | input | 4 | [0] reverse direction, [1] direction/clock mode, [2] 4X counting, [3] invert index |
| filt_len_i | input | FILT_W | Number of samples a new level must hold before it is accepted |
| max_pos_i | input | POS_W | Position wrap limit |
| cmp_pos_i | input | 3*POS_W | Three position compare values, channel i at [i*POS_W +: POS_W] |
| idx_cmp_i | input | IDX_W | Index compare value |
| clr_pos_i | input | 1 | Clear position pulse |
| clr_idx_i | input | 1 | Clear index count pulse |
| arm_idx_clr_i | input | 1 | Arm a clear of the position on the next index pulse |
| pos_o | output | POS_W | Position count |
| idx_cnt_o | output | IDX_W | Index pulse count |
| dir_o | output | 1 | Direction of the last counted step, 1 = up |
| ev_step_o | output | 1 | Counted step event |
| ev_dir_o | output | 1 | Direction change event |
| ev_err_o | output | 1 | Phase error event |
| ev_idx_o | output | 1 | Index pulse event |
| pos_hit_o | output | 3 | Position compare matches |
| rev_hit_o | output | 1 | Index compare match |
| combo_hit_o | output | 3 | Position match and index match together |

## Verification
Up and down gray-code walks that pass the wrap limit several times show whether 4X, 2X and reversed counting move the position by the right amount in the right direction. Double-phase jumps separate a phase error from a counted step. In direction/clock mode, sequences of A changes and B edges check that only a rising B edge counts. A sweep of filter lengths uses glitches one cycle shorter than the threshold and pulses exactly at the threshold, which locates the acceptance boundary. Index pulses at both polarities, together with compare values hit during a position sweep, check the match outputs, the clear commands and the one-shot clear on index.

// File: rtl/qdec_pkg.sv
package qdec_pkg;
  localparam int CFG_W       = 4;
  localparam int CFG_INV_DIR = 0;
  localparam int CFG_DIRCLK  = 1;
  localparam int CFG_X4      = 2;
  localparam int CFG_IDX_INV = 3;
  localparam int N_CMP       = 3;
  localparam int N_IN        = 3;  // a, b, index
endpackage

// File: rtl/qdec_filter.sv
module qdec_filter #(
  parameter int W      = 3,
  parameter int FILT_W = 18
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [W-1:0]      raw_i,
  input  logic [FILT_W-1:0] len_i,
  output logic [W-1:0]      flt_o
);
  localparam int CW = FILT_W + 1;

  for (genvar g = 0; g < W; g++) begin : g_ch
    logic s1_q, s2_q, st_q;
    logic [FILT_W-1:0] cnt_q;
    logic [CW-1:0] cnt_nxt;
    assign cnt_nxt = {1'b0, cnt_q} + CW'(1);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        s1_q  <= 1'b0;
        s2_q  <= 1'b0;
        st_q  <= 1'b0;
        cnt_q <= '0;
      end else begin
        s1_q <= raw_i[g];
        s2_q <= s1_q;
        if (s2_q == st_q) begin
          cnt_q <= '0;
        end else if (cnt_nxt >= {1'b0, len_i}) begin
          // new level held long enough (a length of 0 acts as 1)
          st_q  <= s2_q;
          cnt_q <= '0;
        end else begin
          cnt_q <= cnt_nxt[FILT_W-1:0];
        end
      end
    end
    assign flt_o[g] = st_q;
  end
endmodule

// File: rtl/qdec_decode.sv
module qdec_decode (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic a_i,
  input  logic b_i,
  input  logic inv_dir_i,
  input  logic dirclk_i,
  input  logic x4_i,
  output logic step_o,
  output logic up_o,
  output logic err_o,
  output logic dir_chg_o,
  output logic dir_o
);
  logic pa_q, pb_q, dir_q;
  logic da, db, fwd;

  assign da = a_i ^ pa_q;
  assign db = b_i ^ pb_q;

  always_comb begin
    if (dirclk_i) begin
      step_o = b_i & ~pb_q;
      err_o  = 1'b0;
      fwd    = a_i;
    end else begin
      err_o  = da & db;
      step_o = x4_i ? (da ^ db) : (da & ~db);
      fwd    = a_i ^ pb_q;  // A leading B
    end
  end

  assign up_o      = fwd ^ inv_dir_i;
  assign dir_chg_o = step_o & (up_o != dir_q);
  assign dir_o     = dir_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pa_q  <= 1'b0;
      pb_q  <= 1'b0;
      dir_q <= 1'b1;
    end else begin
      pa_q <= a_i;
      pb_q <= b_i;
      if (step_o) dir_q <= up_o;
    end
  end
endmodule

// File: rtl/qdec_index.sv
module qdec_index #(
  parameter int IDX_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             idx_i,
  input  logic             inv_i,
  input  logic             clr_i,
  input  logic [IDX_W-1:0] cmp_i,
  output logic             pulse_o,
  output logic [IDX_W-1:0] cnt_o,
  output logic             hit_o
);
  logic act, act_q;
  logic [IDX_W-1:0] cnt_q;

  assign act     = idx_i ^ inv_i;
  assign pulse_o = act & ~act_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      act_q <= act;
      if (clr_i)        cnt_q <= '0;
      else if (pulse_o) cnt_q <= cnt_q + IDX_W'(1);
    end
  end

  assign cnt_o = cnt_q;
  assign hit_o = (cnt_q == cmp_i);
endmodule

// File: rtl/qdec_poscnt.sv
module qdec_poscnt #(
  parameter int POS_W = 32,
  parameter int N_CMP = 3
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   step_i,
  input  logic                   up_i,
  input  logic                   clr_i,
  input  logic                   arm_i,
  input  logic                   idx_pulse_i,
  input  logic [POS_W-1:0]       max_i,
  input  logic [N_CMP*POS_W-1:0] cmp_i,
  output logic [POS_W-1:0]       pos_o,
  output logic [N_CMP-1:0]       hit_o
);
  logic [POS_W-1:0] pos_q, pos_step;
  logic armed_q;

  always_comb begin
    if (up_i) pos_step = (pos_q == max_i) ? '0 : pos_q + POS_W'(1);
    else      pos_step = (pos_q == '0) ? max_i : pos_q - POS_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_q   <= '0;
      armed_q <= 1'b0;
    end else begin
      if (clr_i)                      pos_q <= '0;
      else if (armed_q & idx_pulse_i) pos_q <= '0;
      else if (step_i)                pos_q <= pos_step;

      if (armed_q & idx_pulse_i) armed_q <= 1'b0;
      else if (arm_i)            armed_q <= 1'b1;
    end
  end

  for (genvar i = 0; i < N_CMP; i++) begin : g_cmp
    assign hit_o[i] = (pos_q == cmp_i[i*POS_W +: POS_W]);
  end

  assign pos_o = pos_q;
endmodule

// File: rtl/qdec.sv
module qdec
  import qdec_pkg::*;
#(
  parameter int POS_W  = 32,
  parameter int IDX_W  = 32,
  parameter int FILT_W = 18
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               a_i,
  input  logic               b_i,
  input  logic               idx_i,
  input  logic [3:0]         cfg_i,
  input  logic [FILT_W-1:0]  filt_len_i,
  input  logic [POS_W-1:0]   max_pos_i,
  input  logic [3*POS_W-1:0] cmp_pos_i,
  input  logic [IDX_W-1:0]   idx_cmp_i,
  input  logic               clr_pos_i,
  input  logic               clr_idx_i,
  input  logic               arm_idx_clr_i,
  output logic [POS_W-1:0]   pos_o,
  output logic [IDX_W-1:0]   idx_cnt_o,
  output logic               dir_o,
  output logic               ev_step_o,
  output logic               ev_dir_o,
  output logic               ev_err_o,
  output logic               ev_idx_o,
  output logic [2:0]         pos_hit_o,
  output logic               rev_hit_o,
  output logic [2:0]         combo_hit_o
);
  logic [N_IN-1:0] flt;
  logic step, up, err, dir_chg, idx_pulse;
  logic ev_step_q, ev_dir_q, ev_err_q, ev_idx_q;

  qdec_filter #(.W(N_IN), .FILT_W(FILT_W)) u_filter (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .raw_i  ({idx_i, b_i, a_i}),
    .len_i  (filt_len_i),
    .flt_o  (flt)
  );

  qdec_decode u_decode (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .a_i       (flt[0]),
    .b_i       (flt[1]),
    .inv_dir_i (cfg_i[CFG_INV_DIR]),
    .dirclk_i  (cfg_i[CFG_DIRCLK]),
    .x4_i      (cfg_i[CFG_X4]),
    .step_o    (step),
    .up_o      (up),
    .err_o     (err),
    .dir_chg_o (dir_chg),
    .dir_o     (dir_o)
  );

  qdec_index #(.IDX_W(IDX_W)) u_index (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .idx_i   (flt[2]),
    .inv_i   (cfg_i[CFG_IDX_INV]),
    .clr_i   (clr_idx_i),
    .cmp_i   (idx_cmp_i),
    .pulse_o (idx_pulse),
    .cnt_o   (idx_cnt_o),
    .hit_o   (rev_hit_o)
  );

  qdec_poscnt #(.POS_W(POS_W), .N_CMP(N_CMP)) u_poscnt (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .step_i      (step),
    .up_i        (up),
    .clr_i       (clr_pos_i),
    .arm_i       (arm_idx_clr_i),
    .idx_pulse_i (idx_pulse),
    .max_i       (max_pos_i),
    .cmp_i       (cmp_pos_i),
    .pos_o       (pos_o),
    .hit_o       (pos_hit_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ev_step_q <= 1'b0;
      ev_dir_q  <= 1'b0;
      ev_err_q  <= 1'b0;
      ev_idx_q  <= 1'b0;
    end else begin
      ev_step_q <= step;
      ev_dir_q  <= dir_chg;
      ev_err_q  <= err;
      ev_idx_q  <= idx_pulse;
    end
  end

  assign ev_step_o   = ev_step_q;
  assign ev_dir_o    = ev_dir_q;
  assign ev_err_o    = ev_err_q;
  assign ev_idx_o    = ev_idx_q;
  assign combo_hit_o = pos_hit_o & {N_CMP{rev_hit_o}};
endmodule

// File: rtl/qdec_chk.sv
module qdec_chk #(
  parameter int POS_W = 32,
  parameter int IDX_W = 32
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             clr_pos_i,
  input logic             clr_idx_i,
  input logic [POS_W-1:0] max_pos_i,
  input logic [POS_W-1:0] pos_o,
  input logic [IDX_W-1:0] idx_cnt_o,
  input logic             dir_o,
  input logic             ev_step_o,
  input logic             ev_err_o,
  input logic             ev_idx_o
);
  a_r6_err_no_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_err_o |-> !ev_step_o);

  a_r2_hold_without_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ev_step_o && !ev_idx_o && !$past(clr_pos_i)) |-> $stable(pos_o));

  a_r2_step_up: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev_step_o && dir_o && !ev_idx_o && !$past(clr_pos_i) &&
     ($past(pos_o) != $past(max_pos_i))) |-> (pos_o == $past(pos_o) + POS_W'(1)));

  a_r4_wrap_down: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev_step_o && !dir_o && !ev_idx_o && !$past(clr_pos_i) &&
     ($past(pos_o) == '0)) |-> (pos_o == $past(max_pos_i)));

  a_r11_clr_pos: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(clr_pos_i) |-> (pos_o == '0));

  a_r11_clr_idx: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(clr_idx_i) |-> (idx_cnt_o == '0));

  a_r9_idx_inc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev_idx_o && !$past(clr_idx_i)) |-> (idx_cnt_o == $past(idx_cnt_o) + IDX_W'(1)));
endmodule

bind qdec qdec_chk #(.POS_W(POS_W), .IDX_W(IDX_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .clr_pos_i (clr_pos_i),
  .clr_idx_i (clr_idx_i),
  .max_pos_i (max_pos_i),
  .pos_o     (pos_o),
  .idx_cnt_o (idx_cnt_o),
  .dir_o     (dir_o),
  .ev_step_o (ev_step_o),
  .ev_err_o  (ev_err_o),
  .ev_idx_o  (ev_idx_o)
);

// File: tb/qdec_tb.sv
module qdec_tb;
  localparam int PW = 8, IW = 8, FW = 4;
  localparam logic [PW-1:0] MAXP = 8'd13;

  logic clk = 0, rst_n = 0;
  logic a = 0, b = 0, idx = 0;
  logic [3:0] cfg = 4'b0100;
  logic [FW-1:0] filt = 4'd1;
  logic [PW-1:0] maxp = MAXP;
  logic [3*PW-1:0] cmp = {8'd7, 8'd5, 8'd3};
  logic [IW-1:0] icmp = 8'd2;
  logic clr_pos = 0, clr_idx = 0, arm = 0;
  logic [PW-1:0] pos;
  logic [IW-1:0] icnt;
  logic dir, ev_step, ev_dir, ev_err, ev_idx, rev_hit;
  logic [2:0] pos_hit, combo;

  int checks = 0, errors = 0, cyc = 0;
  int n_step = 0, n_dir = 0, n_err = 0, n_idx = 0;
  int qs = 0;
  logic [PW-1:0] ep = 0;
  logic [IW-1:0] ei = 0;

  always #4 clk = ~clk;  // 125 MHz

  qdec #(.POS_W(PW), .IDX_W(IW), .FILT_W(FW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .a_i(a), .b_i(b), .idx_i(idx), .cfg_i(cfg),
    .filt_len_i(filt), .max_pos_i(maxp), .cmp_pos_i(cmp), .idx_cmp_i(icmp),
    .clr_pos_i(clr_pos), .clr_idx_i(clr_idx), .arm_idx_clr_i(arm),
    .pos_o(pos), .idx_cnt_o(icnt), .dir_o(dir), .ev_step_o(ev_step),
    .ev_dir_o(ev_dir), .ev_err_o(ev_err), .ev_idx_o(ev_idx),
    .pos_hit_o(pos_hit), .rev_hit_o(rev_hit), .combo_hit_o(combo)
  );

  always @(negedge clk) if (rst_n) begin
    if (ev_step) n_step++;
    if (ev_dir)  n_dir++;
    if (ev_err)  n_err++;
    if (ev_idx)  n_idx++;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog: act=%0d exp<=150000 cycles", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic settle();
    repeat (int'(filt) + 6) @(negedge clk);
  endtask

  function automatic logic [PW-1:0] nxt(logic [PW-1:0] p, logic up);
    if (up) return (p == maxp) ? '0 : p + 1'b1;
    return (p == 0) ? maxp : p - 1'b1;
  endfunction

  // gray order {a,b}: 00,10,11,01
  task automatic qmove(logic up);
    int ns;
    logic counted;
    ns = up ? (qs + 1) % 4 : (qs + 3) % 4;
    counted = cfg[2] || (((qs == 0 || qs == 3) && (ns == 1 || ns == 2)) ||
                         ((qs == 1 || qs == 2) && (ns == 0 || ns == 3)));
    @(negedge clk);
    a = (ns == 1 || ns == 2);
    b = (ns == 2 || ns == 3);
    qs = ns;
    settle();
    if (counted) ep = nxt(ep, up ^ cfg[0]);
  endtask

  task automatic pulse_idx();
    @(negedge clk); idx = ~idx; settle();
    @(negedge clk); idx = ~idx; settle();
  endtask

  task automatic one_cycle(ref logic sig);
    @(negedge clk); sig = 1; @(negedge clk); sig = 0; settle();
  endtask

  initial begin
    int s0, d0, e0;
    repeat (5) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1
    chk("R1 pos", pos, 0); chk("R1 idx", icnt, 0); chk("R1 dir", dir, 1);
    chk("R1 events", {ev_step, ev_dir, ev_err, ev_idx}, 0);

    // R2 R4 R13: 4X walks across the wrap in both directions
    cfg = 4'b0100; s0 = n_step; d0 = n_dir;
    for (int i = 0; i < 30; i++) begin qmove(1); chk("R2/R4 4X up", pos, ep); end
    for (int i = 0; i < 30; i++) begin qmove(0); chk("R2/R4 4X down", pos, ep); end
    chk("R13 step events", n_step - s0, 60);
    chk("R13 dir events", n_dir - d0, 1);
    chk("R13 dir level", dir, 0);

    // R3: 2X counts only A changes
    cfg = 4'b0000; s0 = n_step;
    for (int i = 0; i < 16; i++) begin qmove(1); chk("R3 2X up", pos, ep); end
    chk("R3 2X step count", n_step - s0, 8);

    // R5: reversed direction
    cfg = 4'b0101;
    for (int i = 0; i < 10; i++) begin qmove(1); chk("R5 reversed", pos, ep); end
    chk("R5 dir", dir, 0);

    // R6: both phases change in one sample
    cfg = 4'b0100; e0 = n_err; s0 = n_step;
    @(negedge clk); qs = (qs + 2) % 4;
    a = (qs == 1 || qs == 2); b = (qs == 2 || qs == 3); settle();
    chk("R6 error event", n_err - e0, 1);
    chk("R6 no step", n_step - s0, 0);
    chk("R6 pos kept", pos, ep);

    // R11 then R10 compare sweep
    one_cycle(clr_pos); ep = 0;
    chk("R11 clr_pos", pos, 0);
    for (int i = 0; i < 14; i++) begin
      qmove(1);
      chk("R10 pos_hit", pos_hit, {ep == 7, ep == 5, ep == 3});
      chk("R10 combo idle", combo, 0);
    end

    // R9: index pulses, active high
    s0 = n_idx;
    pulse_idx(); pulse_idx(); ei = 2;
    chk("R9 idx count", icnt, ei); chk("R9 idx events", n_idx - s0, 2);
    chk("R10 rev_hit", rev_hit, 1);
    while (ep != 5) qmove(1);
    chk("R10 combo", combo, 3'b010);

    // R9: inverted polarity
    @(negedge clk); idx = 1; settle(); ei++;
    chk("R9 rise normal", icnt, ei);
    @(negedge clk); cfg[3] = 1; settle();
    chk("R9 invert no count", icnt, ei);
    pulse_idx(); ei++;
    chk("R9 inverted pulse", icnt, ei);
    @(negedge clk); cfg[3] = 0; settle(); ei++;
    @(negedge clk); idx = 0; settle();
    chk("R9 back to normal", icnt, ei);

    // R11 clr_idx
    one_cycle(clr_idx); ei = 0;
    chk("R11 clr_idx", icnt, 0);

    // R12: one-shot clear on index
    one_cycle(clr_pos); ep = 0;
    qmove(1); qmove(1); qmove(1);
    one_cycle(arm);
    qmove(1);
    chk("R12 armed not cleared yet", pos, 4);
    pulse_idx(); ep = 0;
    chk("R12 cleared on index", pos, 0);
    qmove(1); qmove(1);
    pulse_idx();
    chk("R12 one shot", pos, 2);

    // R7: direction/clock mode
    cfg = 4'b0010; s0 = n_step;
    @(negedge clk); a = 1; b = 0; settle();
    chk("R7 setup no count", n_step - s0, 0);
    @(negedge clk); b = 1; settle(); ep = nxt(ep, 1);
    chk("R7 rise up", pos, ep);
    @(negedge clk); b = 0; settle();
    chk("R7 fall ignored", pos, ep);
    @(negedge clk); a = 0; settle();
    chk("R7 A ignored", pos, ep);
    @(negedge clk); b = 1; settle(); ep = nxt(ep, 0);
    chk("R7 rise down", pos, ep);
    @(negedge clk); b = 0; settle(); qs = 0;
    chk("R7 total steps", n_step - s0, 2);

    // R8: filter threshold sweep
    cfg = 4'b0100;
    for (int n = 2; n <= 6; n++) begin
      @(negedge clk); filt = FW'(n); settle();
      s0 = n_step;
      @(negedge clk); a = 1; repeat (n - 1) @(negedge clk); a = 0; settle();
      chk("R8 short glitch ignored", n_step - s0, 0);
      @(negedge clk); a = 1; repeat (n) @(negedge clk); a = 0; settle();
      chk("R8 full pulse accepted", n_step - s0, 2);
      chk("R8 pos net", pos, ep);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule